// File: doc/BRIEF.md
# Gated Edge Counter with Reference Timebase

This block measures an external signal's frequency by counting its rising edges over a window of known length. A reference clock of known rate drives an internal timebase counter. A start strobe opens the window. The window shuts in the very cycle that the timebase reaches the terminal value for the chosen gate length. No extra cycle of delay is added between the compare match and the gate closing. The edge total collected during the window is then latched as the result.

The measured signal is asynchronous to the reference clock. It passes through a two-flop synchronizer and a rising-edge detector before it is counted, so the input must toggle at less than half the reference rate. Three gate lengths can be selected, spaced a decade or more apart. With a 40 MHz reference, the default terminal values give gates of 1 s, 10 s and 1000 s. A 10 MHz input over the 10 s gate reads 100,000,000 counts. The result may read one count low or high, because the input edges are not aligned to the gate. This is ordinary quantization and not a fault. The result counter saturates and raises an overflow flag instead of wrapping, which can only happen on the longest gate.

Top module: `freq_gate_counter`

## Requirements
- R1: During and just after reset, busy, valid, overflow and count are all 0.
- R2: A start strobe sampled high while busy is low raises busy on that edge. The gate length is then N reference cycles, where N is GATE0_CYC for gate_sel code 0, GATE1_CYC for code 1, and GATE2_CYC for codes 2 and 3.
- R3: Call the accepting edge t. valid is high for exactly one cycle, after edge t+N, and busy falls on that same edge.
- R4: An input rising edge first sampled by the reference clock at edge k is counted if and only if t-1 <= k <= t+N-2. This reflects the two-cycle synchronizer latency. The cycle of the compare match is included, and nothing after it is counted.
- R5: When the number of counted edges exceeds the largest value of count, count holds all ones and overflow is 1. Otherwise overflow is 0.
- R6: A start strobe that arrives while busy is high has no effect on the window timing or the result.
- R7: gate_sel is sampled only on the accepting edge. Changing it during a window does not change the window's length.
- R8: count and overflow keep their value from one valid pulse until the next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference timebase clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sig_in | input | 1 | Asynchronous signal under measurement |
| gate_sel | input | 2 | Gate length code: 0, 1, or 2/3 for the longest |
| start | input | 1 | Start strobe for one measurement |
| count | output | CNT_W | Latched edge count of the last window |
| overflow | output | 1 | Last result saturated |
| valid | output | 1 | One-cycle pulse when a new result is latched |
| busy | output | 1 | A window is in progress |

## Verification
The bench sweeps the input period, duty cycle and phase against the window start. This exercises the edges just inside and just outside both window boundaries. A gate that closed one cycle late, or that missed the edge in the match cycle, would read one count off for a subset of the phases. The longest gate is driven at the maximum input rate to force saturation: a wrapping counter would report a small number with overflow low. Restarts and gate_sel changes in the middle of a window check that the latched length is kept. A design that re-armed on the second start would produce its valid pulse late and an inflated count.

// File: rtl/freq_gate_pkg.sv
package freq_gate_pkg;

  typedef enum logic [1:0] {
    GATE_SHORT = 2'd0,
    GATE_MID   = 2'd1,
    GATE_LONG  = 2'd2
  } gate_sel_e;

  // Codes 2 and 3 both select the longest gate.
  function automatic gate_sel_e decode_sel(input logic [1:0] code);
    case (code)
      2'd0:    return GATE_SHORT;
      2'd1:    return GATE_MID;
      default: return GATE_LONG;
    endcase
  endfunction

endpackage

// File: rtl/edge_sync_detect.sv
module edge_sync_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_o
);
  logic meta_q, sync_q, last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      last_q <= 1'b0;
    end else begin
      meta_q <= async_in;
      sync_q <= meta_q;
      last_q <= sync_q;
    end
  end

  assign rise_o = sync_q & ~last_q;
endmodule

// File: rtl/gate_timer.sv
module gate_timer
  import freq_gate_pkg::*;
#(
  parameter int          REF_W     = 36,
  parameter longint unsigned GATE0_CYC = 64'd40_000_000,
  parameter longint unsigned GATE1_CYC = 64'd400_000_000,
  parameter longint unsigned GATE2_CYC = 64'd40_000_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       arm_i,
  input  logic [1:0] sel_i,
  output logic       open_o,
  output logic       close_o
);
  localparam logic [REF_W-1:0] TERM0 = REF_W'(GATE0_CYC - 64'd1);
  localparam logic [REF_W-1:0] TERM1 = REF_W'(GATE1_CYC - 64'd1);
  localparam logic [REF_W-1:0] TERM2 = REF_W'(GATE2_CYC - 64'd1);

  logic [REF_W-1:0] ref_q;
  logic [REF_W-1:0] term_q;
  logic [REF_W-1:0] term_pick;
  logic             open_q;

  always_comb begin
    unique case (decode_sel(sel_i))
      GATE_SHORT: term_pick = TERM0;
      GATE_MID:   term_pick = TERM1;
      default:    term_pick = TERM2;
    endcase
  end

  // Compare match closes the gate in the same cycle.
  assign close_o = open_q && (ref_q == term_q);
  assign open_o  = open_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      ref_q  <= '0;
      term_q <= '0;
    end else if (arm_i) begin
      open_q <= 1'b1;
      ref_q  <= '0;
      term_q <= term_pick;
    end else if (open_q) begin
      if (close_o) open_q <= 1'b0;
      else         ref_q  <= ref_q + 1'b1;
    end
  end
endmodule

// File: rtl/edge_accum.sv
module edge_accum #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             edge_i,
  input  logic             close_i,
  output logic [CNT_W-1:0] result_o,
  output logic             ovf_o,
  output logic             valid_o
);
  localparam logic [CNT_W-1:0] ALL_ONES = '1;

  logic [CNT_W-1:0] acc_q, acc_nxt;
  logic             sat_q, sat_nxt;

  function automatic logic [CNT_W:0] sat_step(input logic [CNT_W-1:0] cur,
                                              input logic sat, input logic inc);
    if (!inc)             return {sat, cur};
    if (cur == ALL_ONES)  return {1'b1, ALL_ONES};
    return {sat, cur + 1'b1};
  endfunction

  assign {sat_nxt, acc_nxt} = sat_step(acc_q, sat_q, edge_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q    <= '0;
      sat_q    <= 1'b0;
      result_o <= '0;
      ovf_o    <= 1'b0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= close_i;
      if (clear_i) begin
        acc_q <= '0;
        sat_q <= 1'b0;
      end else begin
        acc_q <= acc_nxt;
        sat_q <= sat_nxt;
      end
      if (close_i) begin
        result_o <= acc_nxt;
        ovf_o    <= sat_nxt;
      end
    end
  end
endmodule

// File: rtl/freq_gate_counter.sv
module freq_gate_counter #(
  parameter int              CNT_W     = 32,
  parameter int              REF_W     = 36,
  parameter longint unsigned GATE0_CYC = 64'd40_000_000,
  parameter longint unsigned GATE1_CYC = 64'd400_000_000,
  parameter longint unsigned GATE2_CYC = 64'd40_000_000_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sig_in,
  input  logic [1:0]       gate_sel,
  input  logic             start,
  output logic [CNT_W-1:0] count,
  output logic             overflow,
  output logic             valid,
  output logic             busy
);
  logic sig_rise;
  logic gate_open;
  logic gate_close;
  logic accept;
  logic gated_edge;

  assign accept     = start & ~gate_open;
  assign gated_edge = sig_rise & gate_open;
  assign busy       = gate_open;

  edge_sync_detect u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (sig_in),
    .rise_o   (sig_rise)
  );

  gate_timer #(
    .REF_W     (REF_W),
    .GATE0_CYC (GATE0_CYC),
    .GATE1_CYC (GATE1_CYC),
    .GATE2_CYC (GATE2_CYC)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm_i   (accept),
    .sel_i   (gate_sel),
    .open_o  (gate_open),
    .close_o (gate_close)
  );

  edge_accum #(.CNT_W(CNT_W)) u_accum (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_i  (accept),
    .edge_i   (gated_edge),
    .close_i  (gate_close),
    .result_o (count),
    .ovf_o    (overflow),
    .valid_o  (valid)
  );
endmodule

// File: rtl/freq_gate_counter_chk.sv
module freq_gate_counter_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             valid,
  input logic             overflow,
  input logic [CNT_W-1:0] count,
  input logic             gate_close,
  input logic             accept
);
  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |=> (!busy && !valid && !overflow && count == '0));

  assert_busy_from_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);

  assert_valid_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);

  assert_close_gives_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    gate_close |=> (valid && !busy));

  assert_sat_all_ones_R5: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> (count == {CNT_W{1'b1}}));

  assert_restart_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !gate_close) |=> (busy && !valid));

  assert_result_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_close |=> ($stable(count) && $stable(overflow)));
endmodule

bind freq_gate_counter freq_gate_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .busy       (busy),
  .valid      (valid),
  .overflow   (overflow),
  .count      (count),
  .gate_close (gate_close),
  .accept     (accept)
);

// File: tb/freq_gate_counter_tb.sv
`timescale 1ns/1ps
module freq_gate_counter_tb;
  localparam int CW = 8;
  localparam int N0 = 40, N1 = 400, N2 = 4000;
  localparam int MAXC = (1 << CW) - 1;

  logic clk = 1'b0, rst_n = 1'b0, sig_in = 1'b0, start = 1'b0;
  logic [1:0] gate_sel = 2'd0;
  logic [CW-1:0] count;
  logic overflow, valid, busy;

  int tests = 0, fails = 0, cyc = 0;
  int pat_p = 2, pat_h = 1, pat_ph = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  freq_gate_counter #(
    .CNT_W(CW), .REF_W(16),
    .GATE0_CYC(64'(N0)), .GATE1_CYC(64'(N1)), .GATE2_CYC(64'(N2))
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .gate_sel(gate_sel),
    .start(start), .count(count), .overflow(overflow), .valid(valid), .busy(busy)
  );

  function automatic bit pat(input int k);
    return ((k + pat_ph) % pat_p) < pat_h;
  endfunction

  always @(posedge clk) cyc <= cyc + 1;
  // Value sampled at edge cyc+1 is applied at the preceding negedge.
  always @(negedge clk) sig_in <= pat(cyc + 1);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One measurement: gate code, its length, an optional mid-window restart with a new code.
  task automatic measure(input logic [1:0] code, input int n, input bit poke);
    int t, exp_cnt, waited;
    bit exp_ovf;
    logic [CW-1:0] held;
    repeat (6) @(negedge clk);
    gate_sel = code;
    start = 1'b1;
    t = cyc + 1;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, "R2 busy after start", int'(busy), 1);
    if (poke) begin
      repeat (5) @(negedge clk);
      gate_sel = (code == 2'd0) ? 2'd1 : 2'd0;   // R7 change mid-window
      start = 1'b1;                                // R6 restart while busy
      @(negedge clk);
      start = 1'b0;
    end
    exp_cnt = 0;
    for (int k = t - 1; k <= t + n - 2; k++)
      if (pat(k) && !pat(k - 1)) exp_cnt++;
    exp_ovf = exp_cnt > MAXC;
    if (exp_ovf) exp_cnt = MAXC;
    waited = 0;
    while (valid !== 1'b1 && waited < n + 20) begin
      @(negedge clk);
      waited++;
    end
    check(cyc == t + n, poke ? "R6 R7 window length" : "R2 R3 window length", cyc - t, n);
    check(busy === 1'b0, "R3 busy low with valid", int'(busy), 0);
    check(count == CW'(exp_cnt), "R4 R5 edge count", int'(count), exp_cnt);
    check(overflow === exp_ovf, "R5 overflow flag", int'(overflow), int'(exp_ovf));
    held = count;
    @(negedge clk);
    check(valid === 1'b0, "R3 valid one cycle", int'(valid), 0);
    repeat (3) @(negedge clk);
    check(count == held, "R8 result held", int'(count), int'(held));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(busy === 0 && valid === 0 && overflow === 0 && count == 0, "R1 reset state",
          int'(count), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy === 0 && valid === 0 && count == 0, "R1 after release", int'(busy), 0);

    // Sweep period, duty and phase on the two shorter gates.
    for (int p = 2; p <= 7; p++)
      for (int h = 1; h < p; h += (p > 3 ? 2 : 1))
        for (int ph = 0; ph < p; ph++) begin
          pat_p = p; pat_h = h; pat_ph = ph;
          measure(2'd0, N0, 1'b0);
        end
    pat_p = 3; pat_h = 1;
    for (int ph = 0; ph < 3; ph++) begin
      pat_ph = ph;
      measure(2'd1, N1, 1'b0);
    end

    // Restart and gate_sel change while busy.
    pat_p = 4; pat_h = 2; pat_ph = 1;
    measure(2'd0, N0, 1'b1);
    measure(2'd1, N1, 1'b1);

    // Longest gate: saturation at maximum rate, code 3 aliases code 2.
    pat_p = 2; pat_h = 1; pat_ph = 0;
    measure(2'd2, N2, 1'b0);
    pat_p = 50; pat_h = 25; pat_ph = 7;
    measure(2'd3, N2, 1'b0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule